// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block chooses which of four DMA channels may run its next transfer when several ask at once. A channel can compete only when its request line, its own enable bit and the global transfer permit are all high. While no grant is outstanding, the arbiter ranks the competing channels and registers a one-hot grant together with a valid strobe. That grant stays in place until the transfer engine returns a done pulse.

A 2-bit order field selects the ranking. Three settings give fixed orders, and each puts the channels in a different sequence. The fourth setting rotates the ranking: the channel after the one that finished most recently moves to the top. The order field can be changed at any time. A change takes effect at the next arbitration.

Top module: `dma_prio_arb`

## Requirements
- R1: During and right after reset, `grant_o` is 0000 and `grant_valid_o` is 0. The rotation head points at channel 0.
- R2: With `order_i` = 00, the ranking is channel 0, then 1, then 2, then 3.
- R3: With `order_i` = 01, the ranking is channel 0, then 2, then 3, then 1.
- R4: With `order_i` = 10, the ranking is channel 2, then 0, then 1, then 3.
- R5: With `order_i` = 11, the ranking starts at the rotation head and counts upward modulo 4. Every done pulse that closes a grant to channel k sets the head to k+1 modulo 4. This update happens in every order mode.
- R6: Channel i is a candidate only when `req_i[i]`, `chan_en_i[i]` and `permit_i` are all 1. If no channel is a candidate, no grant is issued.
- R7: While `permit_i` is 0, no new grant is issued. A grant that is already out stays held until its done pulse.
- R8: While `grant_valid_o` is 1, `grant_o` is one-hot and does not change until a done pulse arrives. Changes on requests, enables and the order field are ignored during that time.
- R9: A done pulse during a grant clears `grant_o` and `grant_valid_o` on the next clock edge. The arbiter then spends one cycle idle before it can grant again. A done pulse with no grant outstanding has no effect on the grant outputs or on the rotation head.
- R10: An order change made while idle applies to the arbitration in that same cycle.
- R11: When the arbiter is idle and a candidate exists at a clock edge, the grant appears on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Transfer request, one bit per channel |
| chan_en_i | input | 4 | Per-channel enable |
| permit_i | input | 1 | Global transfer permit |
| order_i | input | 2 | Ranking select: 00, 01, 10 fixed; 11 rotating |
| done_i | input | 1 | Transfer-complete pulse from the engine |
| grant_o | output | 4 | One-hot granted channel |
| grant_valid_o | output | 1 | A grant is outstanding |

## Verification
Each fixed order is tried with a request pattern in which all four channels compete. It is then tried with patterns that remove the leading channel step by step, which exposes every pairwise rank that order defines. Patterns that mask channels through their enable bits separate the candidate test from the ranking itself. The rotating mode is driven through a chain of done pulses. Between pulses, the request sets are chosen so that a wrong head position would grant a different channel. Directed sequences change requests, the order field and the permit while a grant is held. They also pulse done while idle, which distinguishes the held state from the idle state.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int NCH   = 4;
    localparam int IDX_W = $clog2(NCH);
    localparam int ORD_W = 2;

    typedef logic [IDX_W-1:0]          ch_idx_t;
    typedef logic [NCH-1:0]            ch_vec_t;
    typedef logic [NCH-1:0][IDX_W-1:0] rank_t;

    typedef enum logic [ORD_W-1:0] {
        ORD_LINEAR   = 2'b00,
        ORD_ZERO_TWO = 2'b01,
        ORD_TWO_ZERO = 2'b10,
        ORD_ROTATE   = 2'b11
    } ord_mode_e;

    typedef struct packed {
        logic    busy;
        ch_vec_t grant;
        ch_idx_t gidx;
        ch_idx_t head;
    } arb_state_t;
endpackage

// File: rtl/arb_rank_table.sv
module arb_rank_table
    import dma_arb_pkg::*;
(
    input  logic [ORD_W-1:0] order_i,
    input  ch_idx_t          head_i,
    output rank_t            rank_o
);
    always_comb begin
        rank_o = '0;
        case (ord_mode_e'(order_i))
            ORD_LINEAR: begin
                for (int p = 0; p < NCH; p++) rank_o[p] = ch_idx_t'(p);
            end
            ORD_ZERO_TWO: begin
                rank_o[0] = ch_idx_t'(0);
                rank_o[1] = ch_idx_t'(2);
                rank_o[2] = ch_idx_t'(3);
                rank_o[3] = ch_idx_t'(1);
            end
            ORD_TWO_ZERO: begin
                rank_o[0] = ch_idx_t'(2);
                rank_o[1] = ch_idx_t'(0);
                rank_o[2] = ch_idx_t'(1);
                rank_o[3] = ch_idx_t'(3);
            end
            default: begin
                for (int p = 0; p < NCH; p++) rank_o[p] = head_i + ch_idx_t'(p);
            end
        endcase
    end
endmodule

// File: rtl/arb_pick.sv
module arb_pick
    import dma_arb_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  ch_vec_t elig_i,
    input  rank_t   rank_i,
    output ch_vec_t win_o,
    output ch_idx_t win_idx_o,
    output logic    hit_o
);
    always_comb begin
        hit_o     = 1'b0;
        win_o     = '0;
        win_idx_o = '0;
        for (int p = 0; p < NCH; p++) begin
            if (!hit_o && elig_i[rank_i[p]]) begin
                hit_o     = 1'b1;
                win_idx_o = rank_i[p];
                win_o     = ch_vec_t'(1) << rank_i[p];
            end
        end
    end

    // R6: the winner is always drawn from the candidate set
    assert_win_is_candidate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> ((win_o & elig_i) == win_o) && $onehot(win_o));
    assert_no_win_without_candidate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (elig_i == '0) |-> !hit_o);
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NCH-1:0]   req_i,
    input  logic [NCH-1:0]   chan_en_i,
    input  logic             permit_i,
    input  logic [ORD_W-1:0] order_i,
    input  logic             done_i,
    output logic [NCH-1:0]   grant_o,
    output logic             grant_valid_o
);
    arb_state_t state_d, state_q;
    rank_t      rank;
    ch_vec_t    elig;
    ch_vec_t    win;
    ch_idx_t    win_idx;
    logic       hit;

    assign elig = req_i & chan_en_i & {NCH{permit_i}};

    arb_rank_table i_rank (
        .order_i (order_i),
        .head_i  (state_q.head),
        .rank_o  (rank)
    );

    arb_pick i_pick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .elig_i    (elig),
        .rank_i    (rank),
        .win_o     (win),
        .win_idx_o (win_idx),
        .hit_o     (hit)
    );

    always_comb begin
        state_d = state_q;
        if (state_q.busy) begin
            if (done_i) begin
                state_d.busy  = 1'b0;
                state_d.grant = '0;
                state_d.head  = state_q.gidx + 1'b1;
            end
        end else if (hit) begin
            state_d.busy  = 1'b1;
            state_d.grant = win;
            state_d.gidx  = win_idx;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign grant_o       = state_q.grant;
    assign grant_valid_o = state_q.busy;

    assert_grant_shape_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_valid_o ? $onehot(grant_o) : (grant_o == '0));
    assert_grant_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_valid_o && !done_i |=> grant_valid_o && $stable(grant_o));
    assert_done_releases_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_valid_o && done_i |=> !grant_valid_o);
    assert_no_grant_when_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !grant_valid_o && !permit_i |=> !grant_valid_o);
    assert_new_grant_eligible_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(grant_valid_o) |-> (($past(req_i & chan_en_i) & grant_o) == grant_o) && $past(permit_i));
    assert_idle_candidate_granted_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !grant_valid_o && permit_i && |(req_i & chan_en_i) |=> grant_valid_o);
endmodule

// File: tb/test_dma_prio_arb.sv
module test_dma_prio_arb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [3:0] en = '0;
    logic       permit = 1'b0;
    logic [1:0] order = '0;
    logic       done = 1'b0;
    logic [3:0] grant;
    logic       gvalid;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dma_prio_arb i_dma_prio_arb (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .chan_en_i(en),
        .permit_i(permit), .order_i(order), .done_i(done),
        .grant_o(grant), .grant_valid_o(gvalid)
    );

    // {order[13:12], req[11:8], en[7:4], expected grant[3:0]}
    localparam logic [13:0] VEC [14] = '{
        {2'b00, 4'b1111, 4'b1111, 4'b0001},
        {2'b00, 4'b1110, 4'b1111, 4'b0010},
        {2'b00, 4'b1100, 4'b1111, 4'b0100},
        {2'b00, 4'b1000, 4'b1111, 4'b1000},
        {2'b01, 4'b1111, 4'b1111, 4'b0001},
        {2'b01, 4'b1110, 4'b1111, 4'b0100},
        {2'b01, 4'b1010, 4'b1111, 4'b1000},
        {2'b01, 4'b0010, 4'b1111, 4'b0010},
        {2'b10, 4'b1111, 4'b1111, 4'b0100},
        {2'b10, 4'b1011, 4'b1111, 4'b0001},
        {2'b10, 4'b1010, 4'b1111, 4'b0010},
        {2'b10, 4'b1000, 4'b1111, 4'b1000},
        {2'b00, 4'b1111, 4'b1100, 4'b0100},
        {2'b00, 4'b0011, 4'b1100, 4'b0000}
    };

    task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic expect_grant(input logic [3:0] exp, input string tag);
        chk(grant === exp, tag, grant, exp);
        chk(gvalid === (exp != 4'b0000), tag, {3'b0, gvalid}, {3'b0, exp != 4'b0000});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = '0; done = 1'b0;
        repeat (2) @(negedge clk);
        expect_grant(4'b0000, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_grant(4'b0000, "R1 after reset");
    endtask

    task automatic release_grant();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    initial begin
        en = 4'hF; permit = 1'b1;
        do_reset();

        for (int k = 0; k < 14; k++) begin
            string tag;
            order = VEC[k][13:12];
            req   = VEC[k][11:8];
            en    = VEC[k][7:4];
            if (en != 4'hF)          tag = "R6 enable mask";
            else if (order == 2'b00) tag = "R2 order 00";
            else if (order == 2'b01) tag = "R3 order 01";
            else                     tag = "R4 order 10";
            @(negedge clk);
            expect_grant(VEC[k][3:0], tag);
            req = '0;
            if (gvalid) release_grant();
            @(negedge clk);
            expect_grant(4'b0000, "R9 idle after release");
        end
        en = 4'hF;

        // R8 / R7 / R9 / R10: hold, permit, release, order change
        do_reset();
        order = 2'b00; req = 4'b0010;
        @(negedge clk);
        expect_grant(4'b0010, "R11 one-cycle grant");
        req = 4'b0001; order = 2'b10;
        repeat (3) @(negedge clk);
        expect_grant(4'b0010, "R8 held against new requests");
        permit = 1'b0;
        @(negedge clk);
        expect_grant(4'b0010, "R7 held with permit low");
        release_grant();
        expect_grant(4'b0000, "R9 done clears grant");
        req = 4'b0101;
        repeat (2) @(negedge clk);
        expect_grant(4'b0000, "R7 no grant with permit low");
        permit = 1'b1;
        @(negedge clk);
        expect_grant(4'b0100, "R10 new order applied");
        req = '0;
        release_grant();

        // R9 idle done ignored, R5 rotation
        do_reset();
        release_grant();
        @(negedge clk);
        expect_grant(4'b0000, "R9 idle done ignored");
        order = 2'b11; req = 4'b1111;
        @(negedge clk);
        expect_grant(4'b0001, "R5 head at ch0 after reset");
        release_grant();
        @(negedge clk);
        expect_grant(4'b0010, "R5 head moves to ch1");
        req = 4'b1001;
        release_grant();
        @(negedge clk);
        expect_grant(4'b1000, "R5 head at ch2 picks ch3");
        req = 4'b1111;
        release_grant();
        @(negedge clk);
        expect_grant(4'b0001, "R5 head wraps to ch0");
        req = '0;
        release_grant();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule